// File: doc/BRIEF.md
# Ring Buffer Hold-and-Refresh Controller

This block owns the three address pointers of an audio ring buffer held in external DRAM: the write address (next location to be written), the valid-write address (last location holding good data) and the read address. It sequences those pointers through a pause in which the audio stream stops but the stored samples must be kept alive. The memory timing generator and the serial audio output are outside the block. Both act on the pointers and strobes this block provides.

In normal running, the write sequencer and the read sequencer each advance their own pointer. A stop command freezes only the write side. Raising the refresh flag does four things: it saves the current read address, mutes the output, freezes normal read progress, and starts a loop of read accesses. The loop runs from the saved address up to the valid-write address and then starts over, so the DRAM cells keep being touched without any data being changed. Dropping the flag puts the saved address back into the read pointer and lifts the mute in the same cycle. Writing then waits for a compare command, which places the write pointer just past the valid-write address. Driving the write-enable mode during the hold breaks the pointer relationship, so the block raises a sticky error flag when that happens.

Top module: `rbr_hold_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the state output reads 0 (idle). All four pointers and the refresh address read 0, and mute, access request and error all read 0.
- R2: In idle, start moves the state to 1 (running). While running, each write step records the write address as the valid-write address and then advances the write address. Each read step advances the read address. All pointers count modulo BUF_WORDS, so BUF_WORDS-1 is followed by 0.
- R3: Stop in the running state moves to state 2 (write stopped). In that state write steps are ignored and read steps still advance the read address. A further stop in state 2 changes nothing.
- R4: Refresh high in state 1, 2 or 4 moves the state to 3 (refreshing) on the next cycle. In that cycle the saved read address takes the read address as it was before the edge, and mute reads 1. Read and write steps presented in the cycle that raises refresh are ignored.
- R5: In the refreshing state, the write, valid-write and read addresses hold their values, and read and write steps have no effect.
- R6: The access request equals memory-ready only while the state is refreshing, and is 0 otherwise. The refresh address starts at the saved read address. Each accepted request advances it modulo BUF_WORDS. After an access to the valid-write address, it returns to the saved read address.
- R7: Refresh low in the refreshing state moves the state to 4 (resuming) on the next cycle. In that same cycle the read address equals the saved read address and mute reads 0. While resuming, read steps advance the read address and write steps are ignored.
- R8: Compare in the resuming state moves the state to running and sets the write address to the valid-write address plus one, modulo BUF_WORDS. Compare in any other state is ignored.
- R9: The write-enable mode input high in any cycle whose state is refreshing or resuming sets the error output on the next cycle. The error stays set until reset. The same input has no effect in the other states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin running from idle |
| stop_i | input | 1 | Halt the write sequencer |
| refresh_i | input | 1 | Hold-and-refresh flag (level) |
| compare_i | input | 1 | Resume writing after the valid-write address |
| wr_mode_i | input | 1 | Write-enable mode; illegal during the hold |
| wr_step_i | input | 1 | Write sequencer stored one word |
| rd_step_i | input | 1 | Read sequencer consumed one word |
| mem_rdy_i | input | 1 | Memory can take an access this cycle |
| wa_o | output | AW | Write address |
| vwa_o | output | AW | Valid-write address |
| ra_o | output | AW | Read address |
| ral_o | output | AW | Saved read address |
| rf_addr_o | output | AW | Address of the current refresh access |
| rd_req_o | output | 1 | Refresh read access request |
| mute_o | output | 1 | Output mute |
| state_o | output | 3 | State: 0 idle, 1 running, 2 write stopped, 3 refreshing, 4 resuming |
| seq_err_o | output | 1 | Sticky pointer-relationship error |

## Verification
Some properties are checked by assertions on every cycle:
- the error flag stays set once raised;
- the write-stopped state holds when no refresh arrives;
- the pointers stay frozen through the hold;
- the read address equals the saved address on the first cycle of resuming;
- the refresh loop starts at the saved address.

Other behaviour can only be shown by the directed scenarios: the exact pointer values after mixed write and read traffic, wrap-around at the buffer end, the refresh address walking and returning across the wrap, steps ignored on the edge that raises refresh, compare being ignored outside resuming, and the error flag being set only inside the hold.

// File: rtl/rbr_pkg.sv
// Package rbr_pkg
// Shared state encoding of the ring buffer hold-and-refresh controller.
// Assumes a 3-bit state is enough; the numeric codes are visible at the top port.
package rbr_pkg;
    typedef enum logic [2:0] {
        RB_IDLE    = 3'd0,
        RB_RUN     = 3'd1,
        RB_WSTOP   = 3'd2,
        RB_REFRESH = 3'd3,
        RB_RESUME  = 3'd4
    } rb_state_e;
endpackage

// File: rtl/rbr_fsm.sv
// Module rbr_fsm
// Control sequencer: decides the state and which pointer actions are allowed.
// It also tracks the sticky error raised when write-enable mode is driven during the hold.
// Assumes level-sensitive refresh and single-cycle command pulses.
module rbr_fsm
    import rbr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      stop_i,
    input  logic      refresh_i,
    input  logic      compare_i,
    input  logic      wr_mode_i,
    output rb_state_e state_o,
    output logic      wr_ok_o,
    output logic      rd_ok_o,
    output logic      enter_rf_o,
    output logic      leave_rf_o,
    output logic      cmp_take_o,
    output logic      err_o
);
    rb_state_e state_q, state_d;
    logic      err_q;

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RB_IDLE:    if (start_i) state_d = RB_RUN;
            RB_RUN:     if (refresh_i) state_d = RB_REFRESH;
                        else if (stop_i) state_d = RB_WSTOP;
            RB_WSTOP:   if (refresh_i) state_d = RB_REFRESH;
            RB_REFRESH: if (!refresh_i) state_d = RB_RESUME;
            RB_RESUME:  if (refresh_i) state_d = RB_REFRESH;
                        else if (compare_i) state_d = RB_RUN;
            default:    state_d = RB_IDLE;
        endcase
    end

    // Action strobes for the pointer and scan logic
    always_comb begin
        enter_rf_o = (state_q != RB_REFRESH) && (state_d == RB_REFRESH);
        leave_rf_o = (state_q == RB_REFRESH) && !refresh_i;
        cmp_take_o = (state_q == RB_RESUME) && !refresh_i && compare_i;
        wr_ok_o    = (state_q == RB_RUN) && !refresh_i && !stop_i;
        rd_ok_o    = ((state_q == RB_RUN) || (state_q == RB_WSTOP) ||
                      (state_q == RB_RESUME)) && !refresh_i;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RB_IDLE;
        else        state_q <= state_d;
    end

    // Sticky error on write-enable mode during the hold
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else if (wr_mode_i && ((state_q == RB_REFRESH) || (state_q == RB_RESUME)))
            err_q <= 1'b1;
    end

    assign state_o = state_q;
    assign err_o   = err_q;

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    a_r3_wstop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RB_WSTOP) && !refresh_i |=> state_q == RB_WSTOP);
    a_r7_leave_to_resume: assert property (@(posedge clk) disable iff (!rst_n)
        leave_rf_o |=> state_q == RB_RESUME);
endmodule

// File: rtl/rbr_ptrs.sv
// Module rbr_ptrs
// Holds the write, valid-write, read and saved-read addresses.
// Every pointer wraps modulo BUF_WORDS. Assumes BUF_WORDS <= 2**AW.
module rbr_ptrs #(
    parameter int AW        = 18,
    parameter int BUF_WORDS = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_step_i,
    input  logic          rd_step_i,
    input  logic          wr_ok_i,
    input  logic          rd_ok_i,
    input  logic          in_rf_i,
    input  logic          enter_rf_i,
    input  logic          leave_rf_i,
    input  logic          cmp_take_i,
    output logic [AW-1:0] wa_o,
    output logic [AW-1:0] vwa_o,
    output logic [AW-1:0] ra_o,
    output logic [AW-1:0] ral_o
);
    localparam logic [AW-1:0] LAST = AW'(BUF_WORDS - 1);

    logic [AW-1:0] wa_q, vwa_q, ra_q, ral_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
        return (a == LAST) ? '0 : a + 1'b1;
    endfunction

    // Write-side pointers: advance on a write step, realign on compare
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wa_q  <= '0;
            vwa_q <= '0;
        end else if (cmp_take_i) begin
            wa_q <= bump(vwa_q);
        end else if (wr_ok_i && wr_step_i) begin
            vwa_q <= wa_q;
            wa_q  <= bump(wa_q);
        end
    end

    // Read pointer: advance on a read step, restore at the end of the hold
    always_ff @(posedge clk) begin
        if (!rst_n)                   ra_q <= '0;
        else if (leave_rf_i)          ra_q <= ral_q;
        else if (rd_ok_i && rd_step_i) ra_q <= bump(ra_q);
    end

    // Saved read address: captured when the hold begins
    always_ff @(posedge clk) begin
        if (!rst_n)          ral_q <= '0;
        else if (enter_rf_i) ral_q <= ra_q;
    end

    assign wa_o  = wa_q;
    assign vwa_o = vwa_q;
    assign ra_o  = ra_q;
    assign ral_o = ral_q;

    a_r5_ra_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        in_rf_i && !leave_rf_i |=> $stable(ra_q));
    a_r5_write_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        in_rf_i |=> $stable(wa_q) && $stable(vwa_q));
    a_r7_restore: assert property (@(posedge clk) disable iff (!rst_n)
        leave_rf_i |=> ra_q == ral_q);
    a_r5_ral_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        in_rf_i |=> $stable(ral_q));
endmodule

// File: rtl/rbr_scan.sv
// Module rbr_scan
// Refresh address walker. While the hold is active it issues one read request
// per memory-ready cycle. The addresses run from the saved read address to the
// valid-write address and then start again.
// Assumes the saved address and the valid-write address stay stable through the hold.
module rbr_scan #(
    parameter int AW        = 18,
    parameter int BUF_WORDS = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_rf_i,
    input  logic          enter_rf_i,
    input  logic          mem_rdy_i,
    input  logic [AW-1:0] ra_i,
    input  logic [AW-1:0] ral_i,
    input  logic [AW-1:0] vwa_i,
    output logic [AW-1:0] addr_o,
    output logic          req_o
);
    localparam logic [AW-1:0] LAST = AW'(BUF_WORDS - 1);

    logic [AW-1:0] scan_q;

    // Walk the refresh address, wrapping at the valid-write address
    always_ff @(posedge clk) begin
        if (!rst_n)          scan_q <= '0;
        else if (enter_rf_i) scan_q <= ra_i;
        else if (in_rf_i && mem_rdy_i) begin
            if (scan_q == vwa_i)     scan_q <= ral_i;
            else if (scan_q == LAST) scan_q <= '0;
            else                     scan_q <= scan_q + 1'b1;
        end
    end

    assign addr_o = scan_q;
    assign req_o  = in_rf_i && mem_rdy_i;

    a_r6_loop_starts_at_saved: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_rf_i) |-> scan_q == ral_i);
    a_r6_idle_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
        in_rf_i && !mem_rdy_i && !enter_rf_i |=> $stable(scan_q));
endmodule

// File: rtl/rbr_hold_ctrl.sv
// Module rbr_hold_ctrl
// Top level of the ring buffer hold-and-refresh controller. It joins the
// control sequencer, the pointer bank and the refresh address walker.
// Assumes the DRAM timing generator consumes rd_req_o/rf_addr_o and
// the output path honours mute_o.
module rbr_hold_ctrl
    import rbr_pkg::*;
#(
    parameter int AW        = 18,
    parameter int BUF_WORDS = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          refresh_i,
    input  logic          compare_i,
    input  logic          wr_mode_i,
    input  logic          wr_step_i,
    input  logic          rd_step_i,
    input  logic          mem_rdy_i,
    output logic [AW-1:0] wa_o,
    output logic [AW-1:0] vwa_o,
    output logic [AW-1:0] ra_o,
    output logic [AW-1:0] ral_o,
    output logic [AW-1:0] rf_addr_o,
    output logic          rd_req_o,
    output logic          mute_o,
    output logic [2:0]    state_o,
    output logic          seq_err_o
);
    rb_state_e st;
    logic wr_ok, rd_ok, enter_rf, leave_rf, cmp_take, in_rf;

    rbr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .stop_i(stop_i), .refresh_i(refresh_i),
        .compare_i(compare_i), .wr_mode_i(wr_mode_i),
        .state_o(st), .wr_ok_o(wr_ok), .rd_ok_o(rd_ok),
        .enter_rf_o(enter_rf), .leave_rf_o(leave_rf),
        .cmp_take_o(cmp_take), .err_o(seq_err_o)
    );

    assign in_rf = (st == RB_REFRESH);

    rbr_ptrs #(.AW(AW), .BUF_WORDS(BUF_WORDS)) u_ptrs (
        .clk(clk), .rst_n(rst_n),
        .wr_step_i(wr_step_i), .rd_step_i(rd_step_i),
        .wr_ok_i(wr_ok), .rd_ok_i(rd_ok), .in_rf_i(in_rf),
        .enter_rf_i(enter_rf), .leave_rf_i(leave_rf), .cmp_take_i(cmp_take),
        .wa_o(wa_o), .vwa_o(vwa_o), .ra_o(ra_o), .ral_o(ral_o)
    );

    rbr_scan #(.AW(AW), .BUF_WORDS(BUF_WORDS)) u_scan (
        .clk(clk), .rst_n(rst_n),
        .in_rf_i(in_rf), .enter_rf_i(enter_rf), .mem_rdy_i(mem_rdy_i),
        .ra_i(ra_o), .ral_i(ral_o), .vwa_i(vwa_o),
        .addr_o(rf_addr_o), .req_o(rd_req_o)
    );

    assign mute_o  = in_rf;
    assign state_o = st;

    a_r6_req_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> mem_rdy_i && mute_o);
    a_r4_mute_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        enter_rf |=> mute_o);
endmodule

// File: tb/tb_rbr_hold_ctrl.sv
module tb_rbr_hold_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 18;
    localparam int BW = 8;

    logic clk = 1'b0;
    logic rst_n, start_i, stop_i, refresh_i, compare_i, wr_mode_i;
    logic wr_step_i, rd_step_i, mem_rdy_i;
    logic [AW-1:0] wa_o, vwa_o, ra_o, ral_o, rf_addr_o;
    logic rd_req_o, mute_o, seq_err_o;
    logic [2:0] state_o;
    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rbr_hold_ctrl #(.AW(AW), .BUF_WORDS(BW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .refresh_i(refresh_i), .compare_i(compare_i), .wr_mode_i(wr_mode_i),
        .wr_step_i(wr_step_i), .rd_step_i(rd_step_i), .mem_rdy_i(mem_rdy_i),
        .wa_o(wa_o), .vwa_o(vwa_o), .ra_o(ra_o), .ral_o(ral_o),
        .rf_addr_o(rf_addr_o), .rd_req_o(rd_req_o), .mute_o(mute_o),
        .state_o(state_o), .seq_err_o(seq_err_o)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic ptrs(input string req, input int wa, input int vwa, input int ra);
        chk(req, "wa", int'(wa_o), wa);
        chk(req, "vwa", int'(vwa_o), vwa);
        chk(req, "ra", int'(ra_o), ra);
    endtask

    task automatic do_reset();
        rst_n = 0; start_i = 0; stop_i = 0; refresh_i = 0; compare_i = 0;
        wr_mode_i = 0; wr_step_i = 0; rd_step_i = 0; mem_rdy_i = 0;
        tick(2);
        rst_n = 1;
        tick(1);
    endtask

    // R1: reset values
    task automatic t_reset();
        do_reset();
        chk("R1", "state", int'(state_o), 0);
        ptrs("R1", 0, 0, 0);
        chk("R1", "ral", int'(ral_o), 0);
        chk("R1", "rf_addr", int'(rf_addr_o), 0);
        chk("R1", "mute", int'(mute_o), 0);
        chk("R1", "req", int'(rd_req_o), 0);
        chk("R1", "err", int'(seq_err_o), 0);
    endtask

    // R2: running traffic with wrap; R9: wr_mode ignored while running
    task automatic t_run();
        wr_step_i = 1; tick(1); wr_step_i = 0;
        chk("R2", "wa before start", int'(wa_o), 0);
        start_i = 1; tick(1); start_i = 0;
        chk("R2", "state", int'(state_o), 1);
        wr_step_i = 1; tick(5); wr_step_i = 0;
        ptrs("R2", 5, 4, 0);
        wr_step_i = 1; wr_mode_i = 1; tick(4); wr_step_i = 0; wr_mode_i = 0;
        ptrs("R2", 1, 0, 0);
        chk("R9", "no err in run", int'(seq_err_o), 0);
        rd_step_i = 1; tick(6); rd_step_i = 0;
        chk("R2", "ra", int'(ra_o), 6);
    endtask

    // R3: stop freezes write side only
    task automatic t_stop();
        stop_i = 1; tick(1); stop_i = 0;
        chk("R3", "state", int'(state_o), 2);
        wr_step_i = 1; rd_step_i = 1; tick(1); wr_step_i = 0; rd_step_i = 0;
        ptrs("R3", 1, 0, 7);
        stop_i = 1; tick(1); stop_i = 0;
        chk("R3", "state after 2nd stop", int'(state_o), 2);
        ptrs("R3", 1, 0, 7);
    endtask

    // R4/R5/R6: entry, freeze, refresh loop
    task automatic t_refresh();
        refresh_i = 1; rd_step_i = 1; tick(1); rd_step_i = 0;
        chk("R4", "state", int'(state_o), 3);
        chk("R4", "ral", int'(ral_o), 7);
        chk("R4", "ra unchanged", int'(ra_o), 7);
        chk("R4", "mute", int'(mute_o), 1);
        chk("R6", "req w/o ready", int'(rd_req_o), 0);
        chk("R6", "first addr", int'(rf_addr_o), 7);
        tick(1);
        chk("R6", "addr holds w/o ready", int'(rf_addr_o), 7);
        mem_rdy_i = 1;
        #1 chk("R6", "req", int'(rd_req_o), 1);
        rd_step_i = 1; wr_step_i = 1;
        tick(1);
        chk("R6", "addr wrap to 0", int'(rf_addr_o), 0);
        tick(1);
        chk("R6", "back to saved", int'(rf_addr_o), 7);
        tick(1);
        chk("R6", "again 0", int'(rf_addr_o), 0);
        rd_step_i = 0; wr_step_i = 0; mem_rdy_i = 0;
        ptrs("R5", 1, 0, 7);
    endtask

    // R7/R8: leave hold, resume, compare
    task automatic t_resume();
        refresh_i = 0; tick(1);
        chk("R7", "state", int'(state_o), 4);
        chk("R7", "ra restored", int'(ra_o), 7);
        chk("R7", "mute", int'(mute_o), 0);
        mem_rdy_i = 1;
        #1 chk("R6", "no req outside", int'(rd_req_o), 0);
        mem_rdy_i = 0;
        rd_step_i = 1; wr_step_i = 1; tick(1); rd_step_i = 0; wr_step_i = 0;
        ptrs("R7", 1, 0, 0);
        compare_i = 1; tick(1); compare_i = 0;
        chk("R8", "state", int'(state_o), 1);
        chk("R8", "wa", int'(wa_o), 1);
        wr_step_i = 1; tick(1); wr_step_i = 0;
        compare_i = 1; tick(1); compare_i = 0;
        chk("R8", "compare ignored state", int'(state_o), 1);
        ptrs("R8", 2, 1, 0);
    endtask

    // R9: error flag inside the hold, sticky
    task automatic t_error();
        chk("R9", "err clear", int'(seq_err_o), 0);
        refresh_i = 1; tick(1);
        chk("R4", "direct from run", int'(state_o), 3);
        chk("R4", "ral", int'(ral_o), 0);
        wr_mode_i = 1; tick(1); wr_mode_i = 0;
        chk("R9", "err set", int'(seq_err_o), 1);
        refresh_i = 0; tick(1);
        compare_i = 1; tick(1); compare_i = 0;
        chk("R9", "err sticky", int'(seq_err_o), 1);
        chk("R8", "wa after compare", int'(wa_o), 2);
        do_reset();
        chk("R9", "err cleared by reset", int'(seq_err_o), 0);
    endtask

    initial begin
        t_reset();
        t_run();
        t_stop();
        t_refresh();
        t_resume();
        t_error();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule